// File: doc/BRIEF.md
# Access Rights and Fault Checker

This block decides what a single memory access may do once the translation lookup has already found a matching entry. It takes the entry's rights fields, the current privilege level, the kind of access and four wide protection-identifier registers. From these it produces three results: the permissions that remain granted, a single prioritised fault code, and the privilege a branch would take on when it lands on a gateway page. The block has no registers. Its results follow its inputs within the same cycle, so the surrounding pipeline samples them in the same stage where it presents the lookup result.

The checks run in a fixed order. First comes the rights field, then the protection identifiers, then the status bits of the entry. The status bits cannot block an access that has already been refused. Each status bit also removes permissions, so the caller's cached copy of the result forces the entry to be checked again on the next access. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status level.

Top module: `access_rights_checker`

## Requirements
- R1: Read is granted when cur_priv ≤ ent_pl1, write when cur_priv ≤ ent_pl2, and execute when ent_pl2 ≤ cur_priv ≤ ent_pl1 (a lower number means more privilege).
- R2: ent_type selects the granted rights. Type 0 gives read. Type 1 gives read and write. Type 2 gives read and execute. Type 3 gives all three. Types 4 to 7 give execute only. In perm, bit 0 is read, bit 1 is write and bit 2 is execute.
- R3: acc_kind uses 0 for none, 1 for read, 2 for write and 3 for execute. If the requested right is not granted, fault_code is 1 (instruction protection) for execute and 2 (data rights) otherwise. perm then shows the granted set unchanged.
- R4: The identifier check is skipped when ent_aid is 0 or when pid_chk_en is low.
- R5: A 32-bit identifier slot matches when bits 16:1 of the slot equal ent_aid[15:0]. Higher bits on either side are ignored. If slot bit 0 is set, the match removes write permission.
- R6: Slots are searched starting with the low half of register 0, then its high half, then register 1, and so on. The first match decides. If no slot matches, or the match does not allow the request, fault_code is 3 (data identifier), or 1 for execute. perm then shows the granted set.
- R7: When ent_t is set, only execute permission is kept, and a non-execute access gets fault_code 4 (page reference).
- R8: When ent_d is clear, write permission is removed, and a write gets fault_code 5 (dirty).
- R9: When ent_b is set, write permission is removed, and a write gets fault_code 6 (break). If brk_override is high, the write gets no break fault and write_once is raised instead.
- R10: The status checks are evaluated in the order T, then D, then B, and a later fault replaces an earlier one. A write with T set and D clear reports 5. A dirty fault survives an overridden break.
- R11: acc_kind none bypasses every fault check. It returns the granted set with fault_code 0 and write_once low.
- R12: branch_priv equals ent_type[1:0] when ent_type bit 2 is set and that value is numerically below cur_priv. Otherwise branch_priv equals cur_priv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ent_type | input | 3 | Rights type field of the hit entry |
| ent_pl1 | input | 2 | Least-privileged level allowed to read or execute |
| ent_pl2 | input | 2 | Least-privileged level allowed to write; most-privileged allowed to execute |
| ent_aid | input | 31 | Access identifier of the entry; 0 means public |
| ent_t | input | 1 | Reference trap bit |
| ent_d | input | 1 | Dirty bit |
| ent_b | input | 1 | Break bit |
| cur_priv | input | 2 | Current privilege level |
| acc_kind | input | 2 | Requested access: 0 none, 1 read, 2 write, 3 execute |
| pid_chk_en | input | 1 | Enables the protection identifier check |
| brk_override | input | 1 | Lets one write through a break page |
| pid_regs | input | 256 | Four 64-bit identifier registers, register 0 in the low bits |
| perm | output | 3 | Remaining permissions {exec, write, read} |
| write_once | output | 1 | The write is allowed this time only; invalidate afterwards |
| fault_code | output | 4 | Highest-priority fault, 0 when none |
| branch_priv | output | 2 | Privilege after a branch to this page |

## Verification
The bench builds the block with its default parameters: four 64-bit registers cut into eight 32-bit slots, a 16-bit identifier compare and a 31-bit access identifier. With these values every slot position is reachable, including the last one. The bench can also set identifier bits above the compare width on both the slot and the entry side, and confirm that a match still occurs. The two slots of one register are loaded with conflicting write-disable bits, which exposes whether the low half really takes precedence. Every privilege bound is driven at its edge value.

// File: rtl/acr_pkg.sv
package acr_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_kind_e;

  typedef enum logic [3:0] {
    FLT_NONE        = 4'd0,
    FLT_INST_PROT   = 4'd1,
    FLT_DATA_RIGHTS = 4'd2,
    FLT_DATA_PID    = 4'd3,
    FLT_PAGE_REF    = 4'd4,
    FLT_DIRTY       = 4'd5,
    FLT_BREAK       = 4'd6
  } fault_e;

  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_RD  = 3'b001;
  localparam logic [PERM_W-1:0] PERM_WR  = 3'b010;
  localparam logic [PERM_W-1:0] PERM_EX  = 3'b100;
  localparam logic [PERM_W-1:0] PERM_RX  = 3'b101;
  localparam logic [PERM_W-1:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/acr_rights.sv
module acr_rights #(
  parameter int PRIV_W = 2,
  parameter int TYPE_W = 3
) (
  input  logic [TYPE_W-1:0]      ent_type,
  input  logic [PRIV_W-1:0]      ent_pl1,
  input  logic [PRIV_W-1:0]      ent_pl2,
  input  logic [PRIV_W-1:0]      cur_priv,
  output logic [acr_pkg::PERM_W-1:0] granted
);
  import acr_pkg::*;

  localparam int EXEC_ONLY_BIT = TYPE_W - 1;

  logic rd_ok, wr_ok, ex_ok;

  // privilege bounds: lower number is more privileged
  assign rd_ok = (cur_priv <= ent_pl1);
  assign wr_ok = (cur_priv <= ent_pl2);
  assign ex_ok = (ent_pl2 <= cur_priv) && (cur_priv <= ent_pl1);

  always_comb begin
    if (ent_type[EXEC_ONLY_BIT]) begin
      granted = ex_ok ? PERM_EX : '0;
    end else begin
      granted = '0;
      granted[0] = rd_ok;
      granted[1] = wr_ok & ent_type[0];
      granted[2] = ex_ok & ent_type[1];
    end
  end

endmodule

// File: rtl/acr_pid_match.sv
module acr_pid_match #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 64,
  parameter int SLOT_W   = 32,
  parameter int CMP_W    = 16
) (
  input  logic [NUM_REGS*REG_W-1:0] pid_regs,
  input  logic [CMP_W-1:0]          aid_lo,
  output logic                      hit,
  output logic                      wr_dis
);

  localparam int NUM_SLOTS = (NUM_REGS * REG_W) / SLOT_W;
  localparam logic [SLOT_W-1:0] CMP_MASK = SLOT_W'((64'd1 << CMP_W) - 64'd1);

  logic [NUM_SLOTS-1:0] slot_match;
  logic [NUM_SLOTS-1:0] slot_wd;
  logic [NUM_SLOTS-1:0] first_oh;

  // slot order: low half of a register precedes its high half
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SLOT_W-1:0] slot_val;
    logic [SLOT_W-1:0] diff;
    assign slot_val      = pid_regs[s*SLOT_W +: SLOT_W];
    assign diff          = (slot_val >> 1) ^ SLOT_W'(aid_lo);
    assign slot_match[s] = ~|(diff & CMP_MASK);
    assign slot_wd[s]    = slot_val[0];
  end

  always_comb begin
    first_oh = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (slot_match[s]) begin
        first_oh = '0;
        first_oh[s] = 1'b1;
      end
    end
  end

  assign hit    = |first_oh;
  assign wr_dis = |(first_oh & slot_wd);

  always_comb begin
    // R6
    first_pick_chk: assert ($onehot0(first_oh));
    // R6
    hit_any_chk: assert (hit == (|slot_match));
  end

endmodule

// File: rtl/acr_fault.sv
module acr_fault (
  input  logic [1:0]                 acc_kind,
  input  logic [acr_pkg::PERM_W-1:0] granted,
  input  logic                       pid_on,
  input  logic                       pid_hit,
  input  logic                       pid_wr_dis,
  input  logic                       ent_t,
  input  logic                       ent_d,
  input  logic                       ent_b,
  input  logic                       brk_override,
  output logic [acr_pkg::PERM_W-1:0] perm,
  output logic                       write_once,
  output logic [3:0]                 fault_code
);
  import acr_pkg::*;

  logic [PERM_W-1:0] req;
  logic [PERM_W-1:0] pid_set;
  fault_e            flt;
  logic              is_exec;

  assign is_exec = (acc_kind == ACC_EXEC);

  always_comb begin
    unique case (acc_kind)
      ACC_READ:  req = PERM_RD;
      ACC_WRITE: req = PERM_WR;
      ACC_EXEC:  req = PERM_EX;
      default:   req = '0;
    endcase
  end

  assign pid_set = pid_hit ? (pid_wr_dis ? PERM_RX : PERM_ALL) : '0;

  always_comb begin
    perm       = granted;
    write_once = 1'b0;
    flt        = FLT_NONE;
    if (acc_kind != ACC_NONE) begin
      if (~|(granted & req)) begin
        flt = is_exec ? FLT_INST_PROT : FLT_DATA_RIGHTS;
      end else if (pid_on && ~|(pid_set & req)) begin
        flt = is_exec ? FLT_INST_PROT : FLT_DATA_PID;
      end else begin
        if (pid_on) perm = perm & pid_set;
        // reverse priority: each later check may replace the fault
        if (ent_t) begin
          perm = perm & PERM_EX;
          if (!is_exec) flt = FLT_PAGE_REF;
        end
        if (!ent_d) begin
          perm = perm & PERM_RX;
          if (acc_kind == ACC_WRITE) flt = FLT_DIRTY;
        end
        if (ent_b) begin
          perm = perm & PERM_RX;
          if (acc_kind == ACC_WRITE) begin
            if (brk_override) write_once = 1'b1;
            else              flt = FLT_BREAK;
          end
        end
      end
    end
  end

  assign fault_code = flt;

  always_comb begin
    // R11
    probe_bypass_chk: assert (acc_kind != ACC_NONE ||
                              (fault_code == 4'd0 && !write_once && perm == granted));
    // R8
    dirty_strip_chk: assert (!(acc_kind != ACC_NONE && !ent_d && fault_code > 4'd3) ||
                             !perm[1]);
    // R7
    ref_strip_chk: assert (!(acc_kind != ACC_NONE && ent_t && fault_code > 4'd3) ||
                           perm[1:0] == 2'b00);
    // R9
    once_cause_chk: assert (!write_once ||
                            (acc_kind == ACC_WRITE && ent_b && brk_override));
  end

endmodule

// File: rtl/access_rights_checker.sv
module access_rights_checker #(
  parameter int PRIV_W  = 2,
  parameter int TYPE_W  = 3,
  parameter int AID_W   = 31,
  parameter int CMP_W   = 16,
  parameter int NUM_PID = 4,
  parameter int PID_W   = 64,
  parameter int SLOT_W  = 32
) (
  input  logic [TYPE_W-1:0]        ent_type,
  input  logic [PRIV_W-1:0]        ent_pl1,
  input  logic [PRIV_W-1:0]        ent_pl2,
  input  logic [AID_W-1:0]         ent_aid,
  input  logic                     ent_t,
  input  logic                     ent_d,
  input  logic                     ent_b,
  input  logic [PRIV_W-1:0]        cur_priv,
  input  logic [1:0]               acc_kind,
  input  logic                     pid_chk_en,
  input  logic                     brk_override,
  input  logic [NUM_PID*PID_W-1:0] pid_regs,
  output logic [2:0]               perm,
  output logic                     write_once,
  output logic [3:0]               fault_code,
  output logic [PRIV_W-1:0]        branch_priv
);

  localparam int GATE_BIT = TYPE_W - 1;

  logic [2:0]        granted;
  logic              pid_hit, pid_wr_dis, pid_on;
  logic [PRIV_W-1:0] gate_target;

  acr_rights #(.PRIV_W(PRIV_W), .TYPE_W(TYPE_W)) u_rights (
    .ent_type (ent_type),
    .ent_pl1  (ent_pl1),
    .ent_pl2  (ent_pl2),
    .cur_priv (cur_priv),
    .granted  (granted)
  );

  acr_pid_match #(
    .NUM_REGS (NUM_PID),
    .REG_W    (PID_W),
    .SLOT_W   (SLOT_W),
    .CMP_W    (CMP_W)
  ) u_pid (
    .pid_regs (pid_regs),
    .aid_lo   (ent_aid[CMP_W-1:0]),
    .hit      (pid_hit),
    .wr_dis   (pid_wr_dis)
  );

  // public pages (identifier 0) skip the identifier search
  assign pid_on = pid_chk_en && (|ent_aid);

  acr_fault u_fault (
    .acc_kind     (acc_kind),
    .granted      (granted),
    .pid_on       (pid_on),
    .pid_hit      (pid_hit),
    .pid_wr_dis   (pid_wr_dis),
    .ent_t        (ent_t),
    .ent_d        (ent_d),
    .ent_b        (ent_b),
    .brk_override (brk_override),
    .perm         (perm),
    .write_once   (write_once),
    .fault_code   (fault_code)
  );

  // gateway promotion: only ever toward more privilege
  assign gate_target = ent_type[PRIV_W-1:0];
  assign branch_priv = (ent_type[GATE_BIT] && gate_target < cur_priv) ? gate_target : cur_priv;

  always_comb begin
    // R12
    gate_no_demote_chk: assert (branch_priv <= cur_priv);
    // R3
    refused_keeps_grant_chk: assert (!(fault_code inside {4'd1, 4'd2, 4'd3}) ||
                                     perm == granted);
  end

endmodule

// File: tb/access_rights_checker_bench.sv
module access_rights_checker_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]   ent_type;
  logic [1:0]   ent_pl1, ent_pl2, cur_priv, acc_kind;
  logic [30:0]  ent_aid;
  logic         ent_t, ent_d, ent_b, pid_chk_en, brk_override;
  logic [255:0] pid_regs;
  logic [2:0]   perm;
  logic         write_once;
  logic [3:0]   fault_code;
  logic [1:0]   branch_priv;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  access_rights_checker u_access_rights_checker (
    .ent_type(ent_type), .ent_pl1(ent_pl1), .ent_pl2(ent_pl2), .ent_aid(ent_aid),
    .ent_t(ent_t), .ent_d(ent_d), .ent_b(ent_b), .cur_priv(cur_priv),
    .acc_kind(acc_kind), .pid_chk_en(pid_chk_en), .brk_override(brk_override),
    .pid_regs(pid_regs), .perm(perm), .write_once(write_once),
    .fault_code(fault_code), .branch_priv(branch_priv)
  );

  // {req, type, pl1, pl2, priv, kind, t d b ovr, perm, wo, fault}
  localparam int NV = 17;
  localparam logic [26:0] VEC [NV] = '{
    {4'd2,  3'd0, 2'd3, 2'd3, 2'd0, 2'd1, 4'b0100, 3'b001, 1'b0, 4'd0}, // R2 type0
    {4'd2,  3'd1, 2'd0, 2'd0, 2'd0, 2'd2, 4'b0100, 3'b011, 1'b0, 4'd0}, // R2 type1
    {4'd1,  3'd1, 2'd3, 2'd0, 2'd2, 2'd2, 4'b0100, 3'b001, 1'b0, 4'd2}, // R1 write bound
    {4'd1,  3'd2, 2'd3, 2'd0, 2'd1, 2'd3, 4'b0100, 3'b101, 1'b0, 4'd0}, // R1 exec window
    {4'd3,  3'd2, 2'd1, 2'd1, 2'd2, 2'd3, 4'b0100, 3'b000, 1'b0, 4'd1}, // R3 exec refused
    {4'd2,  3'd5, 2'd3, 2'd0, 2'd3, 2'd1, 4'b0100, 3'b100, 1'b0, 4'd2}, // R2 exec-only
    {4'd7,  3'd3, 2'd3, 2'd0, 2'd0, 2'd3, 4'b1100, 3'b100, 1'b0, 4'd0}, // R7 exec ok
    {4'd7,  3'd3, 2'd3, 2'd0, 2'd0, 2'd1, 4'b1100, 3'b100, 1'b0, 4'd4}, // R7 read faults
    {4'd8,  3'd3, 2'd3, 2'd0, 2'd0, 2'd2, 4'b0000, 3'b101, 1'b0, 4'd5}, // R8 write
    {4'd8,  3'd3, 2'd3, 2'd0, 2'd0, 2'd1, 4'b0000, 3'b101, 1'b0, 4'd0}, // R8 read
    {4'd9,  3'd3, 2'd3, 2'd0, 2'd0, 2'd2, 4'b0110, 3'b101, 1'b0, 4'd6}, // R9 break
    {4'd9,  3'd3, 2'd3, 2'd0, 2'd0, 2'd2, 4'b0111, 3'b101, 1'b1, 4'd0}, // R9 override
    {4'd10, 3'd3, 2'd3, 2'd0, 2'd0, 2'd2, 4'b1000, 3'b100, 1'b0, 4'd5}, // R10 T then D
    {4'd11, 3'd3, 2'd3, 2'd0, 2'd0, 2'd0, 4'b1011, 3'b111, 1'b0, 4'd0}, // R11 probe
    {4'd10, 3'd3, 2'd3, 2'd0, 2'd0, 2'd2, 4'b0011, 3'b101, 1'b1, 4'd5}, // R10 D beats B
    {4'd1,  3'd0, 2'd1, 2'd0, 2'd2, 2'd1, 4'b0100, 3'b000, 1'b0, 4'd2}, // R1 read bound
    {4'd1,  3'd2, 2'd3, 2'd2, 2'd1, 2'd3, 4'b0100, 3'b001, 1'b0, 4'd1}  // R1 exec below pl2
  };

  task automatic check_out(input string tag, input logic [2:0] ep,
                           input logic ew, input logic [3:0] ef);
    @(negedge clk);
    total++;
    if (perm !== ep || write_once !== ew || fault_code !== ef) begin
      bad++;
      $display("FAIL %s: perm=%b wo=%b fault=%0d expected perm=%b wo=%b fault=%0d",
               tag, perm, write_once, fault_code, ep, ew, ef);
    end
  endtask

  task automatic check_gate(input string tag, input logic [1:0] ep);
    @(negedge clk);
    total++;
    if (branch_priv !== ep) begin
      bad++;
      $display("FAIL %s: branch_priv=%0d expected %0d", tag, branch_priv, ep);
    end
  endtask

  task automatic std_entry();
    @(posedge clk);
    ent_type = 3'd3; ent_pl1 = 2'd3; ent_pl2 = 2'd0; cur_priv = 2'd0;
    ent_t = 1'b0; ent_d = 1'b1; ent_b = 1'b0; brk_override = 1'b0;
    pid_chk_en = 1'b1; pid_regs = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: expired expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ent_type = '0; ent_pl1 = '0; ent_pl2 = '0; ent_aid = '0; cur_priv = '0;
    acc_kind = '0; ent_t = 0; ent_d = 0; ent_b = 0; pid_chk_en = 0;
    brk_override = 0; pid_regs = '0;
    // idle state: probe with everything zero (R11, R2, R12)
    check_out("R11 idle", 3'b001, 1'b0, 4'd0);
    check_gate("R12 idle", 2'd0);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      {ent_type, ent_pl1, ent_pl2, cur_priv, acc_kind,
       ent_t, ent_d, ent_b, brk_override} = VEC[i][22:8];
      ent_aid = '0; pid_chk_en = 1'b0; pid_regs = '0;
      check_out($sformatf("R%0d vec%0d", VEC[i][26:23], i),
                VEC[i][7:5], VEC[i][4], VEC[i][3:0]);
    end

    // R5 write-disable match in register 2 high half
    std_entry(); ent_aid = 31'h1234; pid_regs[2*64+32 +: 32] = 32'h2469;
    acc_kind = 2'd1; check_out("R5 wd read", 3'b101, 1'b0, 4'd0);
    @(posedge clk); acc_kind = 2'd2; check_out("R5 wd write", 3'b111, 1'b0, 4'd3);
    @(posedge clk); acc_kind = 2'd3; check_out("R5 wd exec", 3'b101, 1'b0, 4'd0);

    // R6 low half wins over high half of same register
    std_entry(); ent_aid = 31'h1234; acc_kind = 2'd2;
    pid_regs[31:0] = 32'h2469; pid_regs[63:32] = 32'h2468;
    check_out("R6 low first wd", 3'b111, 1'b0, 4'd3);
    std_entry(); ent_aid = 31'h1234; acc_kind = 2'd2;
    pid_regs[31:0] = 32'h2468; pid_regs[63:32] = 32'h2469;
    check_out("R6 low first rw", 3'b111, 1'b0, 4'd0);

    // R6 no match
    std_entry(); ent_aid = 31'h1234; acc_kind = 2'd3;
    check_out("R6 miss exec", 3'b111, 1'b0, 4'd1);
    @(posedge clk); acc_kind = 2'd1; check_out("R6 miss read", 3'b111, 1'b0, 4'd3);

    // R4 public page and disabled check
    std_entry(); ent_aid = 31'h0; acc_kind = 2'd2;
    check_out("R4 public", 3'b111, 1'b0, 4'd0);
    std_entry(); ent_aid = 31'h1234; acc_kind = 2'd2; pid_chk_en = 1'b0;
    check_out("R4 disabled", 3'b111, 1'b0, 4'd0);

    // R5 only low 16 bits compared; last slot reachable (R6)
    std_entry(); ent_aid = 31'h0001_0005; acc_kind = 2'd2;
    pid_regs[3*64 +: 32] = 32'hABCA_000A;
    check_out("R5 masked compare", 3'b111, 1'b0, 4'd0);
    std_entry(); ent_aid = 31'h5; acc_kind = 2'd2;
    pid_regs[3*64+32 +: 32] = 32'h0000_000B;
    check_out("R6 last slot", 3'b111, 1'b0, 4'd3);

    // R12 gateway promotion
    @(posedge clk); ent_type = 3'd6; cur_priv = 2'd3; check_gate("R12 promote", 2'd2);
    @(posedge clk); ent_type = 3'd6; cur_priv = 2'd1; check_gate("R12 no demote", 2'd1);
    @(posedge clk); ent_type = 3'd2; cur_priv = 2'd3; check_gate("R12 not gate", 2'd3);
    @(posedge clk); ent_type = 3'd4; cur_priv = 2'd3; check_gate("R12 to zero", 2'd0);
    @(posedge clk); ent_type = 3'd4; cur_priv = 2'd0; check_gate("R12 equal", 2'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule